// File: doc/BRIEF.md
# Indirect Configuration Port Bridge

This block sits on the host side of a local I/O bus and turns two I/O port locations into configuration cycles on a parallel address/data bus. Software first writes a 32-bit selector into the address port. The selector holds an enable flag, a bus number, a device number, a function number and a register offset. Software then reads or writes the data port. Each data-port access that the selector permits becomes one configuration cycle. The cycle drives a single address phase in which one line of the upper address bits selects the target slot, and the function number and dword index fill the low bits.

The address phase is held stable for a parameterized number of settle cycles before the sample strobe. This gives a slowly rising slot-select line time to reach a valid level. If no target claims the cycle, the read completes with all ones. Accesses that cannot be forwarded complete one cycle after acceptance: the enable flag is clear, the bus is not local, or the device number has no select line. Reads of such accesses return all ones, and writes are dropped. An optional mode carries four extra offset bits from the selector for extended register space.

Top module: `cfg_port_bridge`

## Requirements
- R1: After reset the selector reads as zero, `cfg_req`, `cfg_strobe` and `io_done` are low.
- R2: A write to the address port (byte address 0xCF8..0xCFB) updates only the byte lanes it enables. Bit 31, bits 23:2 and, when `EXT_OFFSET`=1, bits 27:24 are kept. All other bits read back as zero. A read of the address port returns the selector on `io_rdata`.
- R3: During a configuration cycle, `cfg_ad[1:0]`=0, `cfg_ad[7:2]` holds selector bits 7:2, and `cfg_ad[10:8]` holds the function (selector bits 10:8). `cfg_ad[11+d]` is the only upper line set, where d is the device (selector bits 15:11).
- R4: `io_size` encodes 0=byte, 1=halfword, 2 or 3=dword. `cfg_be` is `0001<<io_addr[1:0]` for a byte access, `0011<<(2*io_addr[1])` for a halfword access and `1111` for a dword access.
- R5: A forwarded access holds `cfg_req` with a stable `cfg_ad` for `SETTLE_CYC` cycles. One further cycle follows with `cfg_strobe` high. `io_done` rises on the cycle after the strobe, which is `SETTLE_CYC`+1 clock edges after the acceptance edge.
- R6: A forwarded read returns `cfg_rdata` if `cfg_claim` is high in the strobe cycle, and 0xFFFFFFFF otherwise.
- R7: A data-port access with selector bit 31 clear raises no `cfg_req`. A read returns all ones, a write is dropped, and `io_done` is visible right after the acceptance edge.
- R8: A data-port access with a nonzero bus number (selector bits 23:16) is handled as in R7.
- R9: A device number of `NUM_IDSEL` or more is handled as in R7.
- R10: `cfg_ext` carries selector bits 27:24 during a cycle when `EXT_OFFSET`=1.
- R11: A forwarded write presents `cfg_we`=1 and `cfg_wdata` equal to `io_wdata`. A read presents `cfg_we`=0.
- R12: `io_req` is ignored while an access is in progress, and `io_done` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| io_req | input | 1 | Host access request, sampled while idle |
| io_we | input | 1 | Host access is a write |
| io_addr | input | 16 | Host I/O byte address |
| io_size | input | 2 | Access size: 0 byte, 1 halfword, 2/3 dword |
| io_wdata | input | 32 | Host write data, lane-aligned |
| io_done | output | 1 | Access complete pulse |
| io_rdata | output | 32 | Read data, valid with io_done |
| cfg_req | output | 1 | Configuration cycle in progress |
| cfg_strobe | output | 1 | Sample cycle of the configuration cycle |
| cfg_we | output | 1 | Configuration cycle is a write |
| cfg_ad | output | 32 | Address phase with one-hot slot select |
| cfg_be | output | 4 | Byte enables of the cycle |
| cfg_ext | output | 4 | Extended register offset bits |
| cfg_wdata | output | 32 | Configuration write data |
| cfg_claim | input | 1 | Target claimed the cycle (sampled at strobe) |
| cfg_rdata | input | 32 | Target read data (sampled at strobe) |

## Verification
A corrupted selector shows on the next address-port read-back. It also shows as a wrong slot line, function or dword index on `cfg_ad` in the first cycle of the next forwarded access. A mis-decoded forwarding decision shows immediately in two ways: a `cfg_req` that should or should not appear, and an `io_done` latency of zero instead of `SETTLE_CYC`+1 edges. A wrong settle counter alters the count of `cfg_req` cycles before the strobe. A wrong capture shows as an all-ones or stale `io_rdata` on the completion pulse.

// File: rtl/cfg_port_bridge.sv
module cfg_port_bridge #(
  parameter logic [15:0] ADDR_PORT  = 16'h0CF8,
  parameter logic [15:0] DATA_PORT  = 16'h0CFC,
  parameter int          SETTLE_CYC = 3,
  parameter int          NUM_IDSEL  = 21,
  parameter bit          EXT_OFFSET = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        io_req,
  input  logic        io_we,
  input  logic [15:0] io_addr,
  input  logic [1:0]  io_size,
  input  logic [31:0] io_wdata,
  output logic        io_done,
  output logic [31:0] io_rdata,
  output logic        cfg_req,
  output logic        cfg_strobe,
  output logic        cfg_we,
  output logic [31:0] cfg_ad,
  output logic [3:0]  cfg_be,
  output logic [3:0]  cfg_ext,
  output logic [31:0] cfg_wdata,
  input  logic        cfg_claim,
  input  logic [31:0] cfg_rdata
);

  localparam int CW = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;
  localparam logic [CW-1:0] CNT_INIT = CW'((SETTLE_CYC > 0) ? SETTLE_CYC - 1 : 0);
  localparam logic [31:0] KEEP = 32'h80FF_FFFC | (EXT_OFFSET ? 32'h0F00_0000 : 32'h0);
  localparam logic [31:0] ONES = '1;

  typedef enum logic [1:0] {S_IDLE, S_SETUP, S_SAMPLE, S_DONE} st_t;

  st_t            st;
  logic [CW-1:0]  cnt;
  logic [31:0]    sel_q;
  logic [31:0]    rd_q;
  logic [3:0]     lane;
  logic [31:0]    sel_wr;
  logic [20:0]    idsel;
  logic           fwd_ok;

  wire       hit_a = io_addr[15:2] == ADDR_PORT[15:2];
  wire       hit_d = io_addr[15:2] == DATA_PORT[15:2];
  wire [4:0] dev   = sel_q[15:11];

  always_comb begin
    case (io_size)
      2'd0:    lane = 4'b0001 << io_addr[1:0];
      2'd1:    lane = io_addr[1] ? 4'b1100 : 4'b0011;
      default: lane = 4'b1111;
    endcase
  end

  for (genvar i = 0; i < 4; i++) begin : g_lane
    assign sel_wr[8*i +: 8] = (lane[i] ? io_wdata[8*i +: 8] : sel_q[8*i +: 8]) & KEEP[8*i +: 8];
  end

  assign fwd_ok = sel_q[31] && (sel_q[23:16] == 8'h00) && (int'(dev) < NUM_IDSEL);
  assign idsel  = 21'(1) << dev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cnt       <= '0;
      sel_q     <= '0;
      rd_q      <= '0;
      cfg_we    <= 1'b0;
      cfg_ad    <= '0;
      cfg_be    <= '0;
      cfg_ext   <= '0;
      cfg_wdata <= '0;
    end else begin
      case (st)
        S_IDLE: if (io_req) begin
          if (hit_d && fwd_ok) begin
            cfg_we    <= io_we;
            cfg_ad    <= {idsel, sel_q[10:8], sel_q[7:2], 2'b00};
            cfg_be    <= lane;
            cfg_ext   <= EXT_OFFSET ? sel_q[27:24] : 4'h0;
            cfg_wdata <= io_wdata;
            cnt       <= CNT_INIT;
            st        <= (SETTLE_CYC > 0) ? S_SETUP : S_SAMPLE;
          end else begin
            if (hit_a && io_we) sel_q <= sel_wr;
            rd_q <= (hit_a && !io_we) ? sel_q : ONES;
            st   <= S_DONE;
          end
        end
        S_SETUP: begin
          if (cnt == '0) st <= S_SAMPLE;
          else           cnt <= cnt - 1'b1;
        end
        S_SAMPLE: begin
          rd_q <= cfg_claim ? cfg_rdata : ONES;
          st   <= S_DONE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign cfg_req    = (st == S_SETUP) || (st == S_SAMPLE);
  assign cfg_strobe = st == S_SAMPLE;
  assign io_done    = st == S_DONE;
  assign io_rdata   = rd_q;

  AST_IDSEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) cfg_req |-> $countones(cfg_ad[31:11]) == 1); // R3
  AST_AD_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n) cfg_req |-> cfg_ad[1:0] == 2'b00); // R3
  AST_AD_STABLE: assert property (@(posedge clk) disable iff (!rst_n) (cfg_req && $past(cfg_req)) |-> $stable(cfg_ad)); // R5
  AST_STROBE_IN_REQ: assert property (@(posedge clk) disable iff (!rst_n) cfg_strobe |-> cfg_req); // R5
  AST_STROBE_THEN_DONE: assert property (@(posedge clk) disable iff (!rst_n) cfg_strobe |=> io_done); // R5
  AST_FWD_ENABLED: assert property (@(posedge clk) disable iff (!rst_n) cfg_req |-> sel_q[31]); // R7
  AST_FWD_LOCAL_BUS: assert property (@(posedge clk) disable iff (!rst_n) cfg_req |-> sel_q[23:16] == 8'h00); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) io_done |=> !io_done); // R12

endmodule

// File: tb/sim_cfg_port_bridge.sv
module sim_cfg_port_bridge;
  localparam int CLK_PERIOD = 10;
  localparam int SETTLE = 3;
  localparam int NSEL = 21;
  localparam logic [31:0] KEEP = 32'h8FFF_FFFC;

  logic clk = 0, rst_n = 0;
  logic io_req = 0, io_we = 0;
  logic [15:0] io_addr = 0;
  logic [1:0] io_size = 0;
  logic [31:0] io_wdata = 0;
  logic io_done, cfg_req, cfg_strobe, cfg_we;
  logic [31:0] io_rdata, cfg_ad, cfg_wdata;
  logic [3:0] cfg_be, cfg_ext;
  logic cfg_claim = 0;
  logic [31:0] cfg_rdata = 0;

  int n_chk = 0, n_bad = 0;
  logic [31:0] model = 0;
  logic [31:0] rd_v, ad_v, wd_v;
  logic [3:0] be_v, ext_v;
  logic we_v;
  int edges_v, reqc_v, strc_v;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_port_bridge #(.SETTLE_CYC(SETTLE), .NUM_IDSEL(NSEL), .EXT_OFFSET(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .io_req(io_req), .io_we(io_we), .io_addr(io_addr),
    .io_size(io_size), .io_wdata(io_wdata), .io_done(io_done), .io_rdata(io_rdata),
    .cfg_req(cfg_req), .cfg_strobe(cfg_strobe), .cfg_we(cfg_we), .cfg_ad(cfg_ad),
    .cfg_be(cfg_be), .cfg_ext(cfg_ext), .cfg_wdata(cfg_wdata),
    .cfg_claim(cfg_claim), .cfg_rdata(cfg_rdata));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_be(input logic [1:0] a, input logic [1:0] sz);
    if (sz == 0) return 4'b0001 << a;
    if (sz == 1) return a[1] ? 4'b1100 : 4'b0011;
    return 4'b1111;
  endfunction

  function automatic logic [31:0] exp_ad(input logic [31:0] s);
    return (32'h1 << (11 + s[15:11])) | {21'b0, s[10:8], s[7:2], 2'b00};
  endfunction

  function automatic bit exp_fwd(input logic [31:0] s);
    return s[31] && s[23:16] == 0 && int'(s[15:11]) < NSEL;
  endfunction

  task automatic io(input bit we, input logic [15:0] a, input logic [1:0] sz, input logic [31:0] wd);
    @(negedge clk);
    io_req = 1; io_we = we; io_addr = a; io_size = sz; io_wdata = wd;
    @(posedge clk);
    edges_v = 0; reqc_v = 0; strc_v = 0;
    @(negedge clk);
    io_req = 0;
    while (!io_done) begin
      if (cfg_req) reqc_v++;
      if (cfg_strobe) begin
        strc_v++; ad_v = cfg_ad; be_v = cfg_be; ext_v = cfg_ext; we_v = cfg_we; wd_v = cfg_wdata;
      end
      @(posedge clk); edges_v++; @(negedge clk);
    end
    rd_v = io_rdata;
  endtask

  task automatic sel_write(input logic [1:0] a, input logic [1:0] sz, input logic [31:0] wd);
    logic [3:0] b = exp_be(a, sz);
    io(1, 16'h0CF8 | a, sz, wd);
    for (int i = 0; i < 4; i++) if (b[i]) model[8*i +: 8] = wd[8*i +: 8];
    model &= KEEP;
  endtask

  task automatic data_acc(input bit we, input logic [1:0] a, input logic [1:0] sz, input logic [31:0] wd);
    bit f = exp_fwd(model);
    io(we, 16'h0CFC | a, sz, wd);
    if (f) begin
      chk(edges_v == SETTLE + 1, "R5 latency", edges_v, SETTLE + 1);
      chk(reqc_v == SETTLE + 1 && strc_v == 1, "R5 req/strobe cycles", reqc_v, SETTLE + 1);
      chk(ad_v == exp_ad(model), "R3 address phase", ad_v, exp_ad(model));
      chk(be_v == exp_be(a, sz), "R4 byte enables", be_v, exp_be(a, sz));
      chk(ext_v == model[27:24], "R10 ext offset", ext_v, model[27:24]);
      chk(we_v == we, "R11 write flag", we_v, we);
      if (we) chk(wd_v == wd, "R11 write data", wd_v, wd);
      else chk(rd_v == (cfg_claim ? cfg_rdata : 32'hFFFF_FFFF), "R6 read data", rd_v,
               cfg_claim ? cfg_rdata : 32'hFFFF_FFFF);
    end else begin
      chk(reqc_v == 0 && edges_v == 0, "R7 R8 R9 not forwarded", reqc_v, 0);
      if (!we) chk(rd_v == 32'hFFFF_FFFF, "R7 R8 R9 all ones", rd_v, 32'hFFFF_FFFF);
    end
  endtask

  task automatic sel_check(input string r);
    io(0, 16'h0CF8, 2, 0);
    chk(rd_v == model, r, rd_v, model);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!cfg_req && !cfg_strobe && !io_done, "R1 idle outputs", {cfg_req, cfg_strobe, io_done}, 0);
    rst_n = 1;
    sel_check("R1 selector reset");

    sel_write(0, 2, 32'hFFFF_FFFF);
    sel_check("R2 reserved bits masked");
    sel_write(2, 0, 32'h0055_0000);
    sel_check("R2 byte lane write");
    sel_write(0, 2, 32'h8000_0000);
    sel_write(1, 0, 32'h0000_A300);
    sel_check("R2 byte lane 1");

    // R7: enable clear
    sel_write(0, 2, 32'h0000_0840);
    cfg_claim = 1; cfg_rdata = 32'h1234_5678;
    data_acc(0, 0, 2, 0);
    data_acc(1, 0, 2, 32'hAAAA_5555);
    // R8: nonzero bus
    sel_write(0, 2, 32'h8001_0840);
    data_acc(0, 0, 2, 0);
    // R9: device 20 present, device 21 absent
    sel_write(0, 2, 32'h800A_A7FC);
    sel_write(2, 0, 32'h0);
    data_acc(0, 0, 2, 0);
    sel_write(0, 2, 32'h8000_AF10);
    data_acc(0, 0, 2, 0);
    // R4: byte lane 3 and upper halfword; R6 unclaimed read
    sel_write(0, 2, 32'h8300_1A24);
    data_acc(1, 3, 0, 32'hBB00_0000);
    data_acc(1, 2, 1, 32'hCCDD_0000);
    cfg_claim = 0;
    data_acc(0, 1, 0, 0);
    cfg_claim = 1;
    data_acc(0, 0, 2, 0);

    // R12: request while busy is ignored
    sel_write(0, 2, 32'h8000_1808);
    @(negedge clk);
    io_req = 1; io_we = 0; io_addr = 16'h0CFC; io_size = 2;
    @(posedge clk);
    @(negedge clk);
    io_we = 1; io_addr = 16'h0CF8; io_wdata = 32'h0;
    @(posedge clk);
    @(negedge clk);
    io_req = 0;
    while (!io_done) @(negedge clk);
    @(negedge clk);
    chk(!io_done, "R12 done single pulse", io_done, 0);
    sel_check("R12 busy request ignored");

    for (int it = 0; it < 300; it++) begin
      logic [31:0] s = $urandom;
      logic [1:0] a = 2'($urandom), sz = 2'($urandom);
      s[31] = ($urandom % 8) != 0;
      if ($urandom % 6 != 0) s[23:16] = 0;
      sel_write(0, 2, s);
      if (it % 10 == 0) sel_check("R2 random selector");
      cfg_claim = ($urandom % 4) != 0;
      cfg_rdata = $urandom;
      data_acc(1'($urandom), a, sz, $urandom);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule